// File: doc/BRIEF.md
# Smart card activation sequencer

This block brings a contact smart card up in a fixed order and watches for the card's answer to reset. When a request arrives, the sequencer checks three conditions: a card must be present, no fault may be flagged, and the software reset bit must be low. If all three hold, it turns on the card supply. Once the supply reports good, it starts the card clock and releases the I/O line. It then holds card reset low for a programmable number of card clock ticks before raising it.

After reset rises, the sequencer counts card clock ticks until the first falling edge on the card I/O line. That edge marks the answer to reset, and the tick count at that moment is stored in a capture register. If the tick counter reaches its full range first, the activation has timed out. In automatic mode the sequencer can instead pull reset low and run the delay again, for a parameterised number of retries.

Any of the following starts the shutdown sequence: the card being removed, a fault, the request being withdrawn, or a timeout with no retry left. Shutdown lowers the contacts one at a time, with a fixed number of system clocks between steps.

Top module: `sc_act_seq`

## Requirements
- R1: The supply enable rises on the clock edge that samples all of the following: a request (software or hardware pin), card present, fault low and reset bit low. If any of these is missing, the block stays idle with every output low.
- R2: The supply enable comes on alone first. The clock-run and I/O-enable outputs then rise together on the edge that samples supply-good high, and card reset stays low at that point.
- R3: In automatic mode, card reset rises on the first edge at which the number of card ticks counted since clock-run rose is at least the programmed delay. With a tick on every cycle, that is delay+1 edges after clock-run rose. While no ticks arrive, reset does not rise.
- R4: In manual mode, card reset rises only once the reset bit is high and the delay has elapsed. If the bit is set late, reset rises on the next edge.
- R5: The first falling edge of the card I/O line after reset rises raises the active output. The capture register then holds the number of ticks counted since reset rose: j when the line goes low during the j-th cycle of the answer window, with a tick on every cycle.
- R6: Once active, further I/O edges leave the capture register unchanged.
- R7: If 2^CW ticks pass with no answer and no retry is left, the timeout error flag is set and shutdown begins. With a tick on every cycle, reset is then high for exactly 2^CW cycles.
- R8: In automatic mode, each timeout while retries remain (RETRIES, default 1) pulls reset low without setting the error flag. Reset then rises again after the delay. The timeout after the last retry sets the error flag.
- R9: Card removal, a fault, or withdrawal of the request in any powered state starts shutdown.
- R10: Shutdown pulls reset low on its first edge. Clock-run falls STEP edges later, I/O-enable STEP edges after that, and the supply STEP edges after that, at which point the block returns to idle. The shutdown flag is high throughout the sequence.
- R11: The timeout error flag stays set while the block is idle, and clears on the edge that starts the next activation.
- R12: After reset, every output and the capture register are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_req_i | input | 1 | Software activation request (level) |
| hw_req_i | input | 1 | Hardware activation command pin (level) |
| auto_rst_i | input | 1 | 1 = sequencer drives card reset itself |
| rst_bit_i | input | 1 | Software card reset bit |
| rst_delay_i | input | CW | Card ticks from clock start to reset rise |
| card_present_i | input | 1 | Card detected |
| supply_ok_i | input | 1 | Card supply has reached its level |
| fault_i | input | 1 | Overcurrent, voltage error or power fail |
| cio_i | input | 1 | Card I/O line, synchronised |
| cclk_tick_i | input | 1 | One pulse per card clock cycle |
| vcc_en_o | output | 1 | Card supply enable |
| clk_run_o | output | 1 | Card clock running |
| io_en_o | output | 1 | Card I/O released |
| crst_o | output | 1 | Card reset line |
| capture_o | output | CW | Ticks from reset rise to answer |
| active_o | output | 1 | Answer received, card active |
| atr_err_o | output | 1 | Sticky answer timeout flag |
| deact_o | output | 1 | Shutdown sequence in progress |

## Verification
The checker assumes the following about the inputs: the card I/O line and the tick are already synchronous to the system clock; a tick is a level sampled on each edge; and the I/O line is idle high before the answer window opens, so any falling edge it sees is a real answer. The bench changes every input only at falling clock edges. It holds the tick high on every cycle except in one deliberate stall. It keeps the I/O line high until it chooses the answer cycle. Because of this, the expected delays, capture values and timeout lengths follow directly from cycle arithmetic.

// File: rtl/sc_act_pkg.sv
package sc_act_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PWR, ST_RDLY, ST_ATR, ST_ON, ST_DOWN
  } sc_state_e;
endpackage

// File: rtl/sc_tick_cnt.sv
module sc_tick_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_o <= '0;
    else if (tick_i)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/sc_fall_det.sv
module sc_fall_det (
  input  logic clk,
  input  logic rst,
  input  logic din_i,
  output logic fall_o
);
  logic prev;
  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= din_i;
  end
  assign fall_o = prev & ~din_i;
endmodule

// File: rtl/sc_act_fsm.sv
module sc_act_fsm
  import sc_act_pkg::*;
#(
  parameter int CW      = 16,
  parameter int STEP    = 4,
  parameter int RETRIES = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_i,
  input  logic          auto_mode_i,
  input  logic          rst_bit_i,
  input  logic [CW-1:0] rst_delay_i,
  input  logic          present_i,
  input  logic          supply_ok_i,
  input  logic          fault_i,
  input  logic          tick_i,
  input  logic          io_fall_i,
  input  logic [CW-1:0] cnt_i,
  output logic          cnt_clr_o,
  output logic          vcc_en_o,
  output logic          clk_run_o,
  output logic          io_en_o,
  output logic          crst_o,
  output logic [CW-1:0] capture_o,
  output logic          active_o,
  output logic          atr_err_o,
  output logic          deact_o
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};
  localparam int SW = $clog2(STEP + 1);
  localparam int RW = $clog2(RETRIES + 2);

  sc_state_e     state, state_d;
  logic [SW-1:0] step;
  logic [1:0]    stage;
  logic [RW-1:0] retry;
  logic start, abort, dly_done, ovf, retry_ok, to_fail, step_last;

  always_comb begin
    state_d   = state;
    cnt_clr_o = 1'b1;
    to_fail   = 1'b0;
    start     = (state == ST_IDLE) && req_i && present_i && !fault_i && !rst_bit_i;
    abort     = (state inside {ST_PWR, ST_RDLY, ST_ATR, ST_ON}) &&
                (!present_i || fault_i || !req_i);
    dly_done  = (cnt_i >= rst_delay_i) && (auto_mode_i || rst_bit_i);
    ovf       = tick_i && (cnt_i == CNT_MAX);
    retry_ok  = auto_mode_i && (retry != '0);
    step_last = (step == SW'(STEP - 1));
    case (state)
      ST_IDLE: if (start) state_d = ST_PWR;
      ST_PWR:  if (supply_ok_i) state_d = ST_RDLY;
      ST_RDLY: begin
        if (dly_done) state_d = ST_ATR;
        else          cnt_clr_o = 1'b0;
      end
      ST_ATR: begin
        cnt_clr_o = 1'b0;
        if (io_fall_i) state_d = ST_ON;
        else if (ovf) begin
          cnt_clr_o = 1'b1;
          if (retry_ok) state_d = ST_RDLY;
          else begin
            state_d = ST_DOWN;
            to_fail = 1'b1;
          end
        end
      end
      ST_DOWN: if (step_last && stage == 2'd2) state_d = ST_IDLE;
      default: ;
    endcase
    if (abort) begin
      state_d = ST_DOWN;
      to_fail = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      step      <= '0;
      stage     <= '0;
      retry     <= '0;
      vcc_en_o  <= 1'b0;
      clk_run_o <= 1'b0;
      io_en_o   <= 1'b0;
      crst_o    <= 1'b0;
      capture_o <= '0;
      active_o  <= 1'b0;
      atr_err_o <= 1'b0;
      deact_o   <= 1'b0;
    end else begin
      state    <= state_d;
      active_o <= (state_d == ST_ON);
      deact_o  <= (state_d == ST_DOWN);
      if (state == ST_DOWN) begin
        if (step_last) begin
          step  <= '0;
          stage <= stage + 2'd1;
        end else begin
          step <= step + 1'b1;
        end
      end else begin
        step  <= '0;
        stage <= '0;
      end
      if (start) begin
        vcc_en_o  <= 1'b1;
        atr_err_o <= 1'b0;
        retry     <= RW'(RETRIES);
      end
      if (state == ST_PWR && state_d == ST_RDLY) begin
        clk_run_o <= 1'b1;
        io_en_o   <= 1'b1;
      end
      if (state != ST_ATR && state_d == ST_ATR) crst_o <= 1'b1;
      if (state == ST_ATR && state_d == ST_RDLY) begin
        crst_o <= 1'b0;
        retry  <= retry - 1'b1;
      end
      if (state == ST_ATR && state_d == ST_ON) capture_o <= cnt_i;
      if (to_fail) atr_err_o <= 1'b1;
      if (state != ST_DOWN && state_d == ST_DOWN) crst_o <= 1'b0;
      if (state == ST_DOWN && step_last) begin
        case (stage)
          2'd0:    clk_run_o <= 1'b0;
          2'd1:    io_en_o   <= 1'b0;
          default: vcc_en_o  <= 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/sc_act_seq.sv
module sc_act_seq #(
  parameter int CW      = 16,
  parameter int STEP    = 4,
  parameter int RETRIES = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sw_req_i,
  input  logic          hw_req_i,
  input  logic          auto_rst_i,
  input  logic          rst_bit_i,
  input  logic [CW-1:0] rst_delay_i,
  input  logic          card_present_i,
  input  logic          supply_ok_i,
  input  logic          fault_i,
  input  logic          cio_i,
  input  logic          cclk_tick_i,
  output logic          vcc_en_o,
  output logic          clk_run_o,
  output logic          io_en_o,
  output logic          crst_o,
  output logic [CW-1:0] capture_o,
  output logic          active_o,
  output logic          atr_err_o,
  output logic          deact_o
);
  logic          req, io_fall, cnt_clr;
  logic [CW-1:0] cnt;

  assign req = sw_req_i | hw_req_i;

  sc_tick_cnt #(.W(CW)) u_cnt (
    .clk(clk), .rst(rst), .clr_i(cnt_clr), .tick_i(cclk_tick_i), .cnt_o(cnt)
  );

  sc_fall_det u_fall (
    .clk(clk), .rst(rst), .din_i(cio_i), .fall_o(io_fall)
  );

  sc_act_fsm #(.CW(CW), .STEP(STEP), .RETRIES(RETRIES)) u_fsm (
    .clk(clk), .rst(rst), .req_i(req), .auto_mode_i(auto_rst_i),
    .rst_bit_i(rst_bit_i), .rst_delay_i(rst_delay_i),
    .present_i(card_present_i), .supply_ok_i(supply_ok_i), .fault_i(fault_i),
    .tick_i(cclk_tick_i), .io_fall_i(io_fall), .cnt_i(cnt), .cnt_clr_o(cnt_clr),
    .vcc_en_o(vcc_en_o), .clk_run_o(clk_run_o), .io_en_o(io_en_o),
    .crst_o(crst_o), .capture_o(capture_o), .active_o(active_o),
    .atr_err_o(atr_err_o), .deact_o(deact_o)
  );
endmodule

// File: rtl/sc_act_seq_chk.sv
module sc_act_seq_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          sw_req_i,
  input logic          hw_req_i,
  input logic          rst_bit_i,
  input logic          card_present_i,
  input logic          fault_i,
  input logic          vcc_en_o,
  input logic          clk_run_o,
  input logic          io_en_o,
  input logic          crst_o,
  input logic [CW-1:0] capture_o,
  input logic          active_o,
  input logic          atr_err_o
);
  AST_START_GATED: assert property (@(posedge clk) disable iff (rst)
    $rose(vcc_en_o) |-> $past((sw_req_i | hw_req_i) && card_present_i && !fault_i && !rst_bit_i)); // R1
  AST_IO_NEEDS_VCC: assert property (@(posedge clk) disable iff (rst)
    io_en_o |-> vcc_en_o); // R2
  AST_CLK_NEEDS_IO: assert property (@(posedge clk) disable iff (rst)
    clk_run_o |-> io_en_o); // R10
  AST_RST_NEEDS_CLK: assert property (@(posedge clk) disable iff (rst)
    crst_o |-> clk_run_o); // R3
  AST_ACTIVE_IN_RESET: assert property (@(posedge clk) disable iff (rst)
    active_o |-> crst_o); // R5
  AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (rst)
    !$rose(active_o) |-> $stable(capture_o)); // R6
  AST_ERR_DROPS_RESET: assert property (@(posedge clk) disable iff (rst)
    $rose(atr_err_o) |-> $fell(crst_o)); // R7
  AST_SUPPLY_LAST: assert property (@(posedge clk) disable iff (rst)
    $fell(vcc_en_o) |-> !io_en_o && !clk_run_o && !crst_o); // R10
endmodule

bind sc_act_seq sc_act_seq_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .sw_req_i(sw_req_i), .hw_req_i(hw_req_i),
  .rst_bit_i(rst_bit_i), .card_present_i(card_present_i), .fault_i(fault_i),
  .vcc_en_o(vcc_en_o), .clk_run_o(clk_run_o), .io_en_o(io_en_o),
  .crst_o(crst_o), .capture_o(capture_o), .active_o(active_o),
  .atr_err_o(atr_err_o)
);

// File: tb/sc_act_seq_tb.sv
module sc_act_seq_tb;
  localparam int CLK_P = 10;
  localparam int CW    = 8;
  localparam int STEP  = 3;
  localparam int WIN   = 1 << CW;

  logic clk = 1'b0;
  logic rst, sw_req, hw_req, auto_m, rst_bit, present, sup_ok, fault, cio, tick;
  logic [CW-1:0] dly;
  logic vcc_en, clk_run, io_en, crst, active, atr_err, deact;
  logic [CW-1:0] capture;
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int t, tr, tf, tr2, t0;

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sc_act_seq #(.CW(CW), .STEP(STEP), .RETRIES(1)) u_dut (
    .clk(clk), .rst(rst), .sw_req_i(sw_req), .hw_req_i(hw_req),
    .auto_rst_i(auto_m), .rst_bit_i(rst_bit), .rst_delay_i(dly),
    .card_present_i(present), .supply_ok_i(sup_ok), .fault_i(fault),
    .cio_i(cio), .cclk_tick_i(tick), .vcc_en_o(vcc_en), .clk_run_o(clk_run),
    .io_en_o(io_en), .crst_o(crst), .capture_o(capture), .active_o(active),
    .atr_err_o(atr_err), .deact_o(deact)
  );

  task automatic check(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", rq, act, exp);
    end
  endtask

  task automatic power_up(input int d, input bit am, input bit use_hw, output int tc);
    @(negedge clk);
    dly = CW'(d); auto_m = am; present = 1'b1;
    if (use_hw) hw_req = 1'b1; else sw_req = 1'b1;
    @(negedge clk);
    check("R1 supply on after request", int'(vcc_en), 1);
    check("R2 clock waits for supply", int'(clk_run), 0);
    @(negedge clk);
    check("R2 clock still off", int'({clk_run, io_en}), 0);
    sup_ok = 1'b1;
    @(negedge clk);
    check("R2 clock+io on, reset low", int'({clk_run, io_en, crst}), 3'b110);
    tc = cyc;
  endtask

  task automatic wait_crst(input bit lvl, output int tw);
    for (int i = 0; i < 2000; i++) begin
      if (crst == lvl) break;
      @(negedge clk);
    end
    tw = cyc;
  endtask

  task automatic answer(input int j);
    repeat (j) @(negedge clk);
    cio = 1'b0;
    @(negedge clk);
    check("R5 active after answer", int'(active), 1);
    check("R5 capture value", int'(capture), j);
    cio = 1'b1;
  endtask

  task automatic deact_tail(input int ts);
    int tc2, ti, tv;
    tc2 = 0; ti = 0; tv = 0;
    check("R10 shutdown flag", int'(deact), 1);
    for (int i = 0; i < 100; i++) begin
      if (!clk_run && tc2 == 0) tc2 = cyc;
      if (!io_en && ti == 0) ti = cyc;
      if (!vcc_en) begin tv = cyc; break; end
      @(negedge clk);
    end
    check("R10 clock stop step", tc2 - ts, STEP);
    check("R10 io off step", ti - ts, 2*STEP);
    check("R10 supply off step", tv - ts, 3*STEP);
    check("R10 idle after shutdown", int'({deact, active, crst}), 0);
    sw_req = 1'b0; hw_req = 1'b0; present = 1'b1; fault = 1'b0;
    sup_ok = 1'b0; rst_bit = 1'b0; cio = 1'b1; tick = 1'b1;
    @(negedge clk);
  endtask

  task automatic deact_now();
    @(negedge clk);
    check("R10 reset low first", int'({crst, clk_run}), 2'b01);
    deact_tail(cyc);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; sw_req = 0; hw_req = 0; auto_m = 0; rst_bit = 0; present = 0;
    sup_ok = 0; fault = 0; cio = 1; tick = 1; dly = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R12 outputs after reset",
          int'({vcc_en, clk_run, io_en, crst, active, atr_err, deact}), 0);
    check("R12 capture after reset", int'(capture), 0);

    // R1: each missing condition keeps the block idle
    sw_req = 1'b1; present = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 no card no start", int'(vcc_en), 0);
    present = 1'b1; rst_bit = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset bit blocks start", int'(vcc_en), 0);
    rst_bit = 1'b0; fault = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 fault blocks start", int'(vcc_en), 0);
    sw_req = 1'b0; fault = 1'b0;
    repeat (2) @(negedge clk);

    // R3/R5/R9: delay sweep with varied answer cycle, removal shutdown
    for (int d = 0; d <= 13; d++) begin
      int dd, j;
      dd = (d == 13) ? 255 : d;
      j  = (d * 5) % 23;
      power_up(dd, 1'b1, 1'b0, t);
      wait_crst(1'b1, tr);
      check("R3 auto reset delay", tr - t, dd + 1);
      answer(j);
      repeat (2) @(negedge clk);
      cio = 1'b0;
      @(negedge clk);
      cio = 1'b1;
      @(negedge clk);
      check("R6 capture unchanged", int'(capture), j);
      check("R6 still active", int'(active), 1);
      present = 1'b0;
      deact_now();
    end

    // R3: no ticks, no reset rise
    power_up(5, 1'b1, 1'b0, t);
    tick = 1'b0;
    repeat (20) @(negedge clk);
    check("R3 reset waits for ticks", int'(crst), 0);
    tick = 1'b1; t0 = cyc;
    wait_crst(1'b1, tr);
    check("R3 delay after tick resume", tr - t0, 6);
    answer(3);
    sw_req = 1'b0;
    deact_now();

    // R4: manual mode, reset bit set late
    power_up(4, 1'b0, 1'b0, t);
    repeat (10) @(negedge clk);
    check("R4 manual reset waits for bit", int'(crst), 0);
    rst_bit = 1'b1;
    @(negedge clk);
    check("R4 manual reset follows bit", int'(crst), 1);
    answer(7);
    fault = 1'b1;
    deact_now();

    // R9: fault during delay, hardware request withdrawn during answer window
    power_up(50, 1'b1, 1'b0, t);
    repeat (5) @(negedge clk);
    fault = 1'b1;
    deact_now();
    power_up(2, 1'b1, 1'b1, t);
    wait_crst(1'b1, tr);
    check("R9 hw request activates", tr - t, 3);
    repeat (4) @(negedge clk);
    hw_req = 1'b0;
    deact_now();

    // R7: manual timeout
    power_up(2, 1'b0, 1'b0, t);
    rst_bit = 1'b1;
    wait_crst(1'b1, tr);
    wait_crst(1'b0, tf);
    check("R7 answer window length", tf - tr, WIN);
    check("R7 error flag set", int'(atr_err), 1);
    deact_tail(tf);
    repeat (4) @(negedge clk);
    check("R11 error sticky while idle", int'(atr_err), 1);

    // R8: automatic retry then error; R11 cleared on start
    power_up(3, 1'b1, 1'b0, t);
    check("R11 error cleared by start", int'(atr_err), 0);
    wait_crst(1'b1, tr);
    wait_crst(1'b0, tf);
    check("R8 first window length", tf - tr, WIN);
    check("R8 no error on retry", int'({atr_err, clk_run}), 1);
    wait_crst(1'b1, tr2);
    check("R8 reset reapplied after delay", tr2 - tf, 4);
    wait_crst(1'b0, tf);
    check("R8 second window length", tf - tr2, WIN);
    check("R8 error after last retry", int'(atr_err), 1);
    deact_tail(tf);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule